// File: doc/BRIEF.md
# Phase-Continuous Two-Tone FSK Modulator

This block turns a serial NRZ bit stream into a stream of unsigned sample words for an external DAC. The DAC output is a two-tone FSK carrier for a low-speed process-loop modem. A one (mark) is sent as 1200 Hz and a zero (space) as 2200 Hz, at 1200 bit/s. Timing comes from a 460.8 kHz clock-enable pulse (`tick_i`), which gives exactly 384 ticks per bit.

A phase accumulator runs modulo one carrier period, which is split into `PHASE_STEPS` (2304) steps. On every tick it advances by a per-tone increment: 6 steps for mark and 11 steps for space. With these values a mark bit spans exactly one carrier period and a space bit spans 11/6 periods. The phase is never reloaded when the tone changes, so the waveform has no jumps at bit boundaries. The phase is mapped to a triangle that starts at the rising zero crossing. The triangle is clipped at ±`CLIP` to give a trapezoid, then scaled down and centred on mid-scale. Because the space tone advances the phase faster, its edges are 11/6 as steep as the mark edges, and both tones reach the same peaks.

While the active-low request-to-send input is high, the accumulator and the bit timer are held cleared and the output parks at the bias. When request-to-send goes low, transmission starts from the zero-crossing phase. The first bit's tone is taken at the first tick after that.

Top module: `fsk_mod`

## Requirements
- R1: After reset, `sample_o` equals the bias value 128.
- R2: While `rts_ni` is 1, from the first clock edge that samples it high, `sample_o` is 128 whatever `txd_i` and `tick_i` do.
- R3: With `txd_i` = 1 (mark), the phase advances 6 of 2304 steps per tick: one carrier period per 384 ticks. Starting from phase 0, the sample is 164 after 48 ticks, 192 after 96 ticks and 128 again after 384 ticks.
- R4: With `txd_i` = 0 (space), the phase advances 11 steps per tick. Starting from phase 0, the sample is 140 after 96 ticks and 80 after 384 ticks.
- R5: The tone is taken from `txd_i` only on a tick at a bit boundary, that is the first tick after `rts_ni` falls and every 384th tick after it. Changes of `txd_i` within a bit have no effect on the output.
- R6: At a bit boundary where the tone changes, the phase keeps advancing from where it was. The sample changes by at most 2 codes over that tick.
- R7: On clock edges without `tick_i`, the phase and `sample_o` hold.
- R8: The sample is computed from phase p (0..2303) as follows. v = p for p < 576, v = 1152 − p for p < 1728, and v = p − 2304 otherwise. v is then clipped to ±512. The sample is 128 + floor(v/8). Both tones therefore peak at exactly 192 and bottom out at exactly 64.
- R9: When `rts_ni` goes low, the phase restarts at 0, so the first sample is 128. The first two mark ticks then give 128 and 129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 460.8 kHz sample-rate enable pulse, one clock wide |
| rts_ni | input | 1 | Active-low request to send; high parks the output at the bias |
| txd_i | input | 1 | Serial NRZ data; 1 = mark (1200 Hz), 0 = space (2200 Hz) |
| sample_o | output | 8 | Unsigned DAC sample word, bias 128 |

## Verification
The bench builds the block with its default parameters: 384 ticks per bit, 2304 phase steps per period, increments 6 and 11, clip 512 and shift 3. With these values every expected sample is an exact integer, including whole-bit phase positions, the clipped peaks of both tones and the wrap of the space phase past one period. It drives a tick every second clock, so that no-tick cycles occur during every bit. The bench also releases and reasserts request-to-send in the middle of a bit, which exercises parking at the bias and the restart at the zero crossing.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;
  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;
endpackage

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer #(
  parameter int TICKS_PER_BIT = 384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic bound_o
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign bound_o = (cnt_q == '0);

  assert_cnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < TICKS_PER_BIT);

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> bound_o);
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
  import fsk_mod_pkg::*;
#(
  parameter int PHASE_STEPS = 2304,
  parameter int MARK_INC    = 6,
  parameter int SPACE_INC   = 11,
  parameter int PH_W        = $clog2(PHASE_STEPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic            bound_i,
  input  logic            txd_i,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W:0] MARK_W  = (PH_W+1)'(MARK_INC);
  localparam logic [PH_W:0] SPACE_W = (PH_W+1)'(SPACE_INC);
  localparam logic [PH_W:0] MOD_W   = (PH_W+1)'(PHASE_STEPS);

  tone_e           tone_q, tone_sel;
  logic [PH_W-1:0] phase_q;
  logic [PH_W:0]   inc, sum, wrapped;

  // tone chosen only on the boundary tick; mid-bit data is ignored
  assign tone_sel = bound_i ? tone_e'(txd_i) : tone_q;
  assign inc      = (tone_sel == TONE_MARK) ? MARK_W : SPACE_W;
  assign sum      = {1'b0, phase_q} + inc;
  assign wrapped  = (sum >= MOD_W) ? sum - MOD_W : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tone_q  <= TONE_MARK;
    end else if (clr_i) begin
      phase_q <= '0;
    end else if (tick_i) begin
      phase_q <= wrapped[PH_W-1:0];
      if (bound_i) tone_q <= tone_sel;
    end
  end

  assign phase_o = phase_q;

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=>
      (((int'(phase_q) + PHASE_STEPS - int'($past(phase_q))) % PHASE_STEPS) == MARK_INC) ||
      (((int'(phase_q) + PHASE_STEPS - int'($past(phase_q))) % PHASE_STEPS) == SPACE_INC));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(phase_q));

  assert_tone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && bound_i) |=> $stable(tone_q));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/fsk_shaper.sv
module fsk_shaper #(
  parameter int PHASE_STEPS = 2304,
  parameter int PH_W        = $clog2(PHASE_STEPS),
  parameter int CLIP        = 512,
  parameter int SHIFT       = 3,
  parameter int SAMPLE_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PH_W-1:0]     phase_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int SW      = (PH_W + 2 > SAMPLE_W + 1) ? PH_W + 2 : SAMPLE_W + 1;
  localparam int QUARTER = PHASE_STEPS / 4;
  localparam logic signed [SW-1:0] Q1_S   = SW'(QUARTER);
  localparam logic signed [SW-1:0] Q3_S   = SW'(3 * QUARTER);
  localparam logic signed [SW-1:0] HALF_S = SW'(2 * QUARTER);
  localparam logic signed [SW-1:0] FULL_S = SW'(PHASE_STEPS);
  localparam logic signed [SW-1:0] BIAS_S = SW'(1 << (SAMPLE_W - 1));

  logic signed [SW-1:0] p_s, tri_v, clip_v, sample_full;

  assign p_s = signed'(SW'(phase_i));

  always_comb begin
    if (p_s < Q1_S)      tri_v = p_s;
    else if (p_s < Q3_S) tri_v = HALF_S - p_s;
    else                 tri_v = p_s - FULL_S;
  end

  generate
    if (CLIP < QUARTER) begin : g_trap
      localparam logic signed [SW-1:0] CLIP_S = SW'(CLIP);
      always_comb begin
        if (tri_v > CLIP_S)       clip_v = CLIP_S;
        else if (tri_v < -CLIP_S) clip_v = -CLIP_S;
        else                      clip_v = tri_v;
      end
    end else begin : g_tri
      assign clip_v = tri_v;
    end
  endgenerate

  assign sample_full = BIAS_S + (clip_v >>> SHIFT);
  assign sample_o    = sample_full[SAMPLE_W-1:0];

  assert_fit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_full >= 0) && (int'(sample_full) < (1 << SAMPLE_W)));
endmodule

// File: rtl/fsk_mod.sv
module fsk_mod #(
  parameter int TICKS_PER_BIT = 384,
  parameter int PHASE_STEPS   = 2304,
  parameter int MARK_INC      = 6,
  parameter int SPACE_INC     = 11,
  parameter int CLIP          = 512,
  parameter int SHIFT         = 3,
  parameter int SAMPLE_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rts_ni,
  input  logic                txd_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int PH_W = $clog2(PHASE_STEPS);
  localparam int BIAS = 1 << (SAMPLE_W - 1);
  localparam int PEAK = ((CLIP < PHASE_STEPS / 4) ? CLIP : PHASE_STEPS / 4) >> SHIFT;

  logic            bound;
  logic [PH_W-1:0] phase;

  fsk_bit_timer #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rts_ni),
    .tick_i (tick_i),
    .bound_o(bound)
  );

  fsk_phase_acc #(
    .PHASE_STEPS(PHASE_STEPS),
    .MARK_INC   (MARK_INC),
    .SPACE_INC  (SPACE_INC),
    .PH_W       (PH_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rts_ni),
    .tick_i (tick_i),
    .bound_i(bound),
    .txd_i  (txd_i),
    .phase_o(phase)
  );

  fsk_shaper #(
    .PHASE_STEPS(PHASE_STEPS),
    .PH_W       (PH_W),
    .CLIP       (CLIP),
    .SHIFT      (SHIFT),
    .SAMPLE_W   (SAMPLE_W)
  ) u_shape (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .sample_o(sample_o)
  );

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_ni |=> (int'(sample_o) == BIAS));

  assert_peak_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sample_o) >= BIAS - PEAK) && (int'(sample_o) <= BIAS + PEAK));
endmodule

// File: tb/tb_fsk_mod.sv
module tb_fsk_mod;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rts_ni = 1'b1;
  logic       txd_i = 1'b1;
  logic [7:0] sample_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_phase = 0, m_cnt = 0;
  bit m_tone = 1'b1;

  always #2.5 clk = ~clk;

  fsk_mod dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .rts_ni(rts_ni), .txd_i(txd_i), .sample_o(sample_o)
  );

  function automatic int shape(int p);
    int v;
    if (p < 576)       v = p;
    else if (p < 1728) v = 1152 - p;
    else               v = p - 2304;
    if (v > 512)  v = 512;
    if (v < -512) v = -512;
    return 128 + (v >>> 3);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick(bit b, string req);
    txd_i = b; tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
    @(posedge clk); @(negedge clk);
    if (m_cnt == 0) m_tone = b;
    m_phase = (m_phase + (m_tone ? 6 : 11)) % 2304;
    m_cnt = (m_cnt + 1) % 384;
    check(req, int'(sample_o), shape(m_phase));
  endtask

  task automatic start_tx();
    rts_ni = 1'b0; m_phase = 0; m_cnt = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset bias", int'(sample_o), 128);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 20; i++) begin
      txd_i = i[0]; tick_i = 1'b1;
      @(posedge clk); @(negedge clk);
      tick_i = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R2 idle bias", int'(sample_o), 128);
    end
  endtask

  task automatic t_mark();
    start_tx();
    check("R9 first sample", int'(sample_o), 128);
    for (int i = 1; i <= 384; i++) begin
      do_tick(1'b1, "R3 mark");
      if (i == 48)  check("R3 mark 48 ticks", int'(sample_o), 164);
      if (i == 96)  check("R8 mark peak", int'(sample_o), 192);
      if (i == 384) check("R3 mark full bit", int'(sample_o), 128);
    end
  endtask

  task automatic t_space();
    for (int i = 1; i <= 384; i++) begin
      do_tick(1'b0, "R4 space");
      if (i == 96)  check("R4 space 96 ticks", int'(sample_o), 140);
      if (i == 384) check("R4 space full bit", int'(sample_o), 80);
    end
  endtask

  task automatic t_midbit();
    do_tick(1'b1, "R5 boundary");
    for (int i = 1; i < 384; i++) do_tick(1'b0, "R5 mid-bit ignored");
    check("R5 mid-bit data ignored", int'(sample_o), shape(1920));
  endtask

  task automatic t_continuity();
    int s0, d;
    s0 = int'(sample_o);
    do_tick(1'b0, "R6 switch tick");
    d = int'(sample_o) - s0;
    if (d < 0) d = -d;
    check("R6 step at boundary <= 2", (d <= 2) ? 1 : 0, 1);
    for (int i = 1; i < 384; i++) do_tick(1'b0, "R6 after switch");
  endtask

  task automatic t_range();
    int mn = 255, mx = 0;
    for (int i = 0; i < 384; i++) begin
      do_tick(1'b0, "R8 space shape");
      if (int'(sample_o) < mn) mn = int'(sample_o);
      if (int'(sample_o) > mx) mx = int'(sample_o);
    end
    check("R8 space max", mx, 192);
    check("R8 space min", mn, 64);
  endtask

  task automatic t_notick();
    int s0;
    do_tick(1'b1, "R7 pre");
    s0 = int'(sample_o);
    for (int i = 0; i < 20; i++) begin
      txd_i = i[0];
      @(posedge clk); @(negedge clk);
      check("R7 hold without tick", int'(sample_o), s0);
    end
    do_tick(1'b1, "R7 resume");
  endtask

  task automatic t_release();
    for (int i = 0; i < 40; i++) do_tick(1'b1, "R9 pre-release");
    rts_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 park on release", int'(sample_o), 128);
    for (int i = 0; i < 5; i++) begin
      txd_i = 1'b0; tick_i = 1'b1;
      @(posedge clk); @(negedge clk);
      tick_i = 1'b0;
      check("R2 released ignores ticks", int'(sample_o), 128);
    end
    start_tx();
    check("R9 restart bias", int'(sample_o), 128);
    do_tick(1'b1, "R9 tick 1");
    check("R9 first mark tick", int'(sample_o), 128);
    do_tick(1'b1, "R9 tick 2");
    check("R9 second mark tick", int'(sample_o), 129);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_idle();
    t_mark();
    t_space();
    t_midbit();
    t_continuity();
    t_range();
    t_notick();
    t_release();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule